// File: doc/BRIEF.md
# Synchronous Serial Master with Gated Bit Clock

This block is a serial transmitter and receiver that keeps ordinary asynchronous framing on its data output and also drives a bit clock beside it. Every frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts sixteen baud ticks, and a programmable divisor sets the tick rate. The clock output moves only while data bits are on the line. It rests at the level chosen by the polarity input during idle, start, stop and break. Whether the final data bit gets a clock pulse is a configuration choice.

The receiver does not oversample. Because this block is the clock master, reception runs only while a frame is being sent. The receive input is sampled once per data bit, at the moment the clock edge selected by polarity and phase occurs. Eight samples are assembled into a byte and presented with a one-cycle strobe. A one-byte holding register lets software queue the next byte during a frame, so consecutive frames follow with no idle gap. A break request sends a long run of zeros followed by a stop bit.

Top module: `usm_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `tx` is 1, `sclk` equals `cpol`, and `tx_ready` is 1.
- R2: A frame is a 0 start bit, then `tx_data[0]` through `tx_data[7]`, then a 1 stop bit. Every bit lasts 16 baud ticks, and one baud tick occurs every `div`+1 clock cycles.
- R3: `sclk` stays at `cpol` for the whole of the start bit and the stop bit.
- R4: During a clocked data bit, `sclk` is `cpol` XOR active. With `cpha`=0, active is 1 in ticks 8 to 15 of the bit. With `cpha`=1, active is 1 in ticks 0 to 7.
- R5: With `lbclk`=0, `sclk` stays at `cpol` throughout data bit 7. With `lbclk`=1, that bit is clocked like the others.
- R6: With `rx_en`=1, `rx` is sampled once per data bit at the tick 7 to tick 8 boundary of that bit. After the eighth sample, `rx_valid` is high for exactly one cycle, and `rx_data` then holds the samples with the first sample in bit 0.
- R7: With `rx_en`=0, `rx_valid` never rises.
- R8: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and it goes into the holding register. `tx_ready` is low while that register is full. The held byte starts its frame immediately after the current stop bit, with no idle time in between.
- R9: A pulse on `brk_req` while `busy` is low sends 10 bit times of 0 and then one stop bit of 1, with `sclk` at `cpol` throughout.
- R10: A `brk_req` that arrives while `busy` is high is ignored. The current frame completes unchanged, and the line then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Holding register free |
| brk_req | input | 1 | Break request pulse |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | 0: clock active in second half of bit; 1: first half |
| lbclk | input | 1 | Clock the last data bit |
| rx_en | input | 1 | Receiver enable |
| div | input | 16 | Baud divisor: one tick every div+1 cycles |
| rx | input | 1 | Serial receive data |
| tx | output | 1 | Serial transmit data |
| sclk | output | 1 | Bit clock output |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | Frame in progress or byte held |

## Verification
The assertions assume that `cpol`, `cpha` and `lbclk` do not change while `busy` stays high. They also assume that `div` changes only while the line is idle, because the baud counter is held clear there. The bench changes configuration only after it has seen `busy` low. It returns the transmitted line to `rx`, either directly or inverted, so the expected received byte follows from the sent byte. Break requests are single-cycle pulses, placed either before a frame or in the middle of one.

// File: rtl/usm_pkg.sv
package usm_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int TICK_W        = $clog2(TICKS_PER_BIT);
  localparam int DATA_BITS     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BRK
  } usm_state_e;
endpackage

// File: rtl/usm_baud.sv
module usm_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = !clr && (cnt_q == div);

  always_comb begin
    if (clr || cnt_q == div) cnt_d = '0;
    else                     cnt_d = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: ticks are spaced div+1 cycles apart
  p_tick_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/usm_rx.sv
module usm_rx
  import usm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 rx,
  input  logic                 samp,
  input  logic                 samp_last,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid
);
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 vld_q, vld_d;

  always_comb begin
    sh_d  = sh_q;
    vld_d = 1'b0;
    if (samp && rx_en) begin
      sh_d  = {rx, sh_q[DATA_BITS-1:1]};
      vld_d = samp_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      vld_q <= vld_d;
    end
  end

  assign rx_data  = sh_q;
  assign rx_valid = vld_q;

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_valid_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_en));
endmodule

// File: rtl/usm_tx.sv
module usm_tx
  import usm_pkg::*;
#(
  parameter int BRK_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 brk_req,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic                 lbclk,
  output logic                 tx_ready,
  output logic                 tx,
  output logic                 sclk,
  output logic                 busy,
  output logic                 baud_clr,
  output logic                 samp,
  output logic                 samp_last
);
  localparam int CNT_W = $clog2(BRK_BITS);
  localparam logic [CNT_W-1:0]  LAST_DATA = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0]  LAST_BRK  = CNT_W'(BRK_BITS - 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [TICK_W-1:0] HALF_TICK = TICK_W'(TICKS_PER_BIT / 2);

  usm_state_e           state_q, state_d;
  logic [TICK_W-1:0]    tick_q, tick_d;
  logic [CNT_W-1:0]     bit_q, bit_d;
  logic [DATA_BITS-1:0] shift_q, shift_d, hold_q, hold_d;
  logic                 full_q, full_d;
  logic                 load, end_bit, active;

  assign end_bit = tick && (tick_q == LAST_TICK);

  always_comb begin
    state_d = state_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    hold_d  = hold_q;
    full_d  = full_q;
    load    = 1'b0;
    if (tx_valid && !full_q) begin
      hold_d = tx_data;
      full_d = 1'b1;
    end
    if (state_q == ST_IDLE) begin
      if (full_q) begin
        state_d = ST_START;
        tick_d  = '0;
        load    = 1'b1;
      end else if (brk_req) begin
        state_d = ST_BRK;
        tick_d  = '0;
        bit_d   = '0;
      end
    end else begin
      if (tick) tick_d = tick_q + {{(TICK_W-1){1'b0}}, 1'b1};
      if (end_bit) begin
        if (state_q == ST_START) begin
          state_d = ST_DATA;
          bit_d   = '0;
        end else if (state_q == ST_DATA) begin
          if (bit_q == LAST_DATA) state_d = ST_STOP;
          else begin
            bit_d   = bit_q + {{(CNT_W-1){1'b0}}, 1'b1};
            shift_d = {1'b0, shift_q[DATA_BITS-1:1]};
          end
        end else if (state_q == ST_STOP) begin
          if (full_q) begin
            state_d = ST_START;
            load    = 1'b1;
          end else state_d = ST_IDLE;
        end else begin
          if (bit_q == LAST_BRK) state_d = ST_STOP;
          else bit_d = bit_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
      end
    end
    if (load) begin
      shift_d = hold_q;
      full_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      hold_q  <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      hold_q  <= hold_d;
      full_q  <= full_d;
    end
  end

  assign active    = (state_q == ST_DATA) && (lbclk || bit_q != LAST_DATA) &&
                     (cpha ? (tick_q < HALF_TICK) : (tick_q >= HALF_TICK));
  assign sclk      = cpol ^ active;
  assign tx        = (state_q == ST_DATA) ? shift_q[0] :
                     !(state_q == ST_START || state_q == ST_BRK);
  assign busy      = (state_q != ST_IDLE) || full_q;
  assign tx_ready  = !full_q;
  assign baud_clr  = (state_q == ST_IDLE);
  assign samp      = (state_q == ST_DATA) && tick && (tick_q == HALF_TICK - 1'b1);
  assign samp_last = samp && (bit_q == LAST_DATA);

  p_sclk_framing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START || state_q == ST_STOP) |-> sclk == cpol);
  p_last_bit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && bit_q == LAST_DATA && !lbclk) |-> sclk == cpol);
  p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !load) |=> hold_q == $past(hold_q));
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);
  p_break_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRK) |-> (!tx && sclk == cpol));
  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !tick) |=> $stable(tick_q));
endmodule

// File: rtl/usm_master.sv
module usm_master
  import usm_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int BRK_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 tx_ready,
  input  logic                 brk_req,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic                 lbclk,
  input  logic                 rx_en,
  input  logic [DIV_W-1:0]     div,
  input  logic                 rx,
  output logic                 tx,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 busy
);
  logic [1:0] rsync_q;
  logic       rst_i_n;
  logic       tick, baud_clr, samp, samp_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  usm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_i_n), .clr(baud_clr), .div(div), .tick(tick)
  );

  usm_tx #(.BRK_BITS(BRK_BITS)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .tx_valid(tx_valid),
    .tx_data(tx_data), .brk_req(brk_req), .cpol(cpol), .cpha(cpha),
    .lbclk(lbclk), .tx_ready(tx_ready), .tx(tx), .sclk(sclk), .busy(busy),
    .baud_clr(baud_clr), .samp(samp), .samp_last(samp_last)
  );

  usm_rx u_rx (
    .clk(clk), .rst_n(rst_i_n), .rx_en(rx_en), .rx(rx), .samp(samp),
    .samp_last(samp_last), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> (tx && sclk == cpol && tx_ready));
  p_cfg_steady_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && $past(busy)) |-> $stable({cpol, cpha, lbclk}));
endmodule

// File: tb/usm_master_tb.sv
module usm_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        brk_req = 1'b0;
  logic        cpol = 1'b0, cpha = 1'b0, lbclk = 1'b1, rx_en = 1'b1;
  logic [15:0] div = 16'd1;
  logic        rx_inv = 1'b0;
  logic        rx;
  logic        tx_ready, tx, sclk, rx_valid, busy;
  logic [7:0]  rx_data;

  int checks = 0, fails = 0;
  int rx_cnt = 0;
  logic [7:0]  rx_last = 8'h00;
  logic [31:0] cap_tx, cap_q1, cap_q3;

  always #4 clk = ~clk;
  assign rx = tx ^ rx_inv;

  usm_master u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .brk_req(brk_req), .cpol(cpol), .cpha(cpha),
    .lbclk(lbclk), .rx_en(rx_en), .div(div), .rx(rx), .tx(tx), .sclk(sclk),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
  );

  always @(posedge clk) if (rx_valid) begin
    rx_cnt  <= rx_cnt + 1;
    rx_last <= rx_data;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // bit period 32 cycles (div=1): samples at 8, 16 and 24 cycles into each bit
  task automatic capture(input int nbits);
    int n = 0;
    cap_tx = '0; cap_q1 = '0; cap_q3 = '0;
    @(negedge clk);
    while (tx !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    check(n < 3000, "R2 start seen", 32'(n), 0);
    for (int b = 0; b < nbits; b++) begin
      repeat (8) @(negedge clk); cap_q1[b] = sclk;
      repeat (8) @(negedge clk); cap_tx[b] = tx;
      repeat (8) @(negedge clk); cap_q3[b] = sclk;
      repeat (8) @(negedge clk);
    end
  endtask

  function automatic logic [9:0] frame_bits(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  function automatic logic [9:0] clk_bits(input bit second_half);
    logic [9:0] v = '0;
    for (int b = 1; b <= 8; b++)
      v[b] = cpol ^ ((second_half != cpha) && (lbclk || b != 8));
    v[0] = cpol; v[9] = cpol;
    return v;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(tx == 1'b1 && sclk == cpol && !busy && tx_ready, "R1 reset idle",
          {tx, sclk, busy, tx_ready}, {1'b1, cpol, 1'b0, 1'b1});
  endtask

  task automatic t_frame(input logic [7:0] d, input bit pol, input bit pha,
                         input bit lb, input bit inv, input string tag);
    int c0;
    cpol = pol; cpha = pha; lbclk = lb; rx_inv = inv;
    c0 = rx_cnt;
    send_byte(d);
    capture(10);
    check(cap_tx[9:0] == frame_bits(d), {tag, " R2 frame"}, cap_tx[9:0], frame_bits(d));
    check(cap_q1[9:0] == clk_bits(1'b0), {tag, " R3 R4 sclk first half"},
          cap_q1[9:0], clk_bits(1'b0));
    check(cap_q3[9:0] == clk_bits(1'b1), {tag, " R3 R4 sclk second half"},
          cap_q3[9:0], clk_bits(1'b1));
    check(rx_cnt == c0 + 1 && rx_last == (inv ? ~d : d), {tag, " R6 rx byte"},
          {rx_cnt - c0, rx_last}, {32'd1, inv ? ~d : d});
    wait_idle();
    check(tx == 1'b1 && sclk == cpol, {tag, " R1 idle after frame"}, {tx, sclk}, {1'b1, cpol});
  endtask

  task automatic t_rx_off();
    int c0 = rx_cnt;
    cpol = 0; cpha = 0; lbclk = 1; rx_en = 1'b0;
    send_byte(8'h5A);
    capture(10);
    wait_idle();
    check(rx_cnt == c0, "R7 no strobe when disabled", rx_cnt - c0, 0);
    rx_en = 1'b1;
  endtask

  task automatic t_back_to_back();
    logic [19:0] exp;
    int c0 = rx_cnt;
    cpol = 0; cpha = 1; lbclk = 1; rx_inv = 0;
    send_byte(8'h12);
    fork
      capture(20);
      begin
        send_byte(8'h34);
        check(!tx_ready && busy, "R8 ready low while held", {tx_ready, busy}, 2'b01);
      end
    join
    exp = {frame_bits(8'h34), frame_bits(8'h12)};
    check(cap_tx[19:0] == exp, "R8 back-to-back frames", cap_tx[19:0], exp);
    check(rx_cnt == c0 + 2 && rx_last == 8'h34, "R8 R6 both received",
          {rx_cnt - c0, rx_last}, {32'd2, 8'h34});
    wait_idle();
  endtask

  task automatic t_break();
    cpol = 1; cpha = 0; lbclk = 1;
    fork
      capture(11);
      begin
        @(negedge clk); brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
      end
    join
    check(cap_tx[10:0] == 11'h400, "R9 break line", cap_tx[10:0], 11'h400);
    check(cap_q1[10:0] == {11{cpol}} && cap_q3[10:0] == {11{cpol}}, "R9 break sclk idle",
          {cap_q1[10:0], cap_q3[10:0]}, {22{cpol}});
    wait_idle();
  endtask

  task automatic t_break_busy();
    cpol = 0; cpha = 0; lbclk = 1;
    send_byte(8'h55);
    fork
      capture(10);
      begin
        repeat (100) @(negedge clk); brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
      end
    join
    check(cap_tx[9:0] == frame_bits(8'h55), "R10 frame unchanged", cap_tx[9:0],
          frame_bits(8'h55));
    repeat (100) @(negedge clk);
    check(tx == 1'b1 && !busy, "R10 break ignored", {tx, busy}, 2'b10);
  endtask

  task automatic t_divisor();
    int n = 0, low = 0;
    div = 16'd3;
    send_byte(8'h01);
    while (tx !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    while (tx === 1'b0 && low < 1000) begin @(negedge clk); low++; end
    check(low == 64, "R2 bit length div=3", low, 64);
    wait_idle();
    div = 16'd1;
  endtask

  initial begin
    t_reset();
    t_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, "base");
    t_frame(8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, "pol1pha1");
    t_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, "R5 lastbit off");
    t_frame(8'hE7, 1'b1, 1'b0, 1'b0, 1'b0, "R5 lastbit off pol1");
    t_rx_off();
    t_back_to_back();
    t_break();
    t_break_busy();
    t_divisor();
    summary();
  end
endmodule